// File: doc/BRIEF.md
# Lagged Fibonacci Pattern Generator

This block produces a stream of 32-bit pseudo-random words used as stimulus for cores under test. Each new word is the wrapping sum of two earlier words of the stream: the word from 24 steps back and the word from 55 steps back. The lag pair follows the primitive trinomial x^55 + x^24 + 1, so a properly seeded history yields a very long period.

The last 55 words live in a circular history addressed by one write pointer. The newest sum replaces the oldest entry in the same cycle that it is presented on the output. Before it can run, the history must be filled. Software can write 55 seed words one per cycle, or a single pulse can start an internal 32-bit Galois LFSR that writes 55 consecutive states into the history. A flag warns when every seed word is even, because such a seed cannot reach the full period.

Top module: `lfg_gen`

## Requirements
- R1: While reset is applied and just after it, `word_valid`, `seed_ready` and `seed_all_even` are 0 and `word_out` is zero.
- R2: Each cycle with `seed_load` high (outside an automatic fill) writes `seed_data` into the next history slot, slots 0 to 54 in order. `seed_ready` rises in the cycle after the 55th write.
- R3: With seed words x0..x54, output word n (counted from 55) equals x(n-24) + x(n-55) modulo 2^32. The history wraps after 55 words, and the sequence continues without a break.
- R4: When `seed_ready` is high and `enable` is high (with `seed_load` and `auto_seed` low), exactly one word is produced in that cycle, with `word_valid` high in the same cycle. In every other cycle `word_valid` is 0 and `word_out` is zero.
- R5: A cycle with `enable` low leaves the generator state unchanged. The next enabled cycle delivers the word that would otherwise have come next.
- R6: `seed_all_even` is high exactly when `seed_ready` is high and bit 0 of every word written during the last fill was 0.
- R7: A pulse on `auto_seed` loads the LFSR with the parameter `AUTO_SEED` (default 32'hACE12468). During the next 55 cycles, one state per cycle is written into slots 0 to 54. The step is a right shift; when the bit shifted out is 1, the result is XORed with 32'h80200003. `seed_ready` is high from the 56th cycle after the pulse.
- R8: During an automatic fill, `seed_load`, `enable` and `auto_seed` are ignored: no word is produced, and the filled history equals the pure LFSR sequence.
- R9: A `seed_load` while `seed_ready` is high restarts manual seeding at slot 0, and `seed_ready` drops in the next cycle.
- R10: `auto_seed` takes priority over `seed_load`, and `seed_load` takes priority over `enable`. A cycle with both `seed_load` and `enable` high produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Write `seed_data` into the next history slot |
| seed_data | input | 32 | Seed word |
| auto_seed | input | 1 | Start an automatic fill from the internal LFSR |
| enable | input | 1 | Request one generated word this cycle |
| word_out | output | 32 | Generated word, zero when not valid |
| word_valid | output | 1 | `word_out` carries a new word this cycle |
| seed_ready | output | 1 | History is full and generation is allowed |
| seed_all_even | output | 1 | The last fill held no odd word |

## Verification
The assertions check the following on every cycle:
- a word is only produced when the history is full and `enable` is high, and `word_out` is zero otherwise;
- the pointer stays in range and wraps from 54 to 0;
- an idle cycle changes no state;
- a fill completion raises ready, and a reload drops it;
- an automatic fill is silent.

Only the bench scenarios can show that the values are right. It compares thousands of words against its own model of the recurrence, after manual seeds, after an LFSR seed, and across enable gaps. The same scenarios check the even-seed flag and the restarts of seeding while running.

// File: rtl/lfg_pkg.sv
package lfg_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY,
    ST_MANUAL,
    ST_AUTO,
    ST_RUN
  } lfg_state_e;

  // Modular add for ring indices; base and ofs are both below depth.
  function automatic int ring_add(input int base, input int ofs, input int depth);
    int s;
    s = base + ofs;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/lfg_ptr.sv
module lfg_ptr #(
  parameter int DEPTH = 55,
  parameter int OFS   = 31,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             restart,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PTR_W-1:0] lag_addr,
  output logic [PTR_W-1:0] cur_ptr
);
  logic [PTR_W-1:0] wp_q;

  // A restart writes slot 0 no matter where the pointer rests.
  assign wr_addr  = restart ? '0 : wp_q;
  assign cur_ptr  = wp_q;
  // The slot holding the word from the short lag lies OFS slots ahead of the oldest.
  assign lag_addr = PTR_W'(lfg_pkg::ring_add(int'(wp_q), OFS, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wp_q <= '0;
    else if (clear) wp_q <= '0;
    else if (step)  wp_q <= PTR_W'(lfg_pkg::ring_add(int'(wr_addr), 1, DEPTH));
  end
endmodule

// File: rtl/lfg_hist.sv
module lfg_hist #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 55,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_a_addr,
  input  logic [PTR_W-1:0]  rd_b_addr,
  output logic [WORD_W-1:0] rd_a_data,
  output logic [WORD_W-1:0] rd_b_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/lfg_lfsr.sv
module lfg_lfsr #(
  parameter int                W    = 32,
  parameter logic [W-1:0]      TAPS = 32'h80200003,
  parameter logic [W-1:0]      SEED = 32'hACE12468
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] s_q;

  // Galois form: shift right, fold the taps in when a one falls out.
  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    logic [W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ TAPS;
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s_q <= SEED;
    else if (load) s_q <= SEED;
    else if (step) s_q <= advance(s_q);
  end

  assign state = s_q;
endmodule

// File: rtl/lfg_gen.sv
module lfg_gen #(
  parameter int                 WORD_W    = 32,
  parameter int                 DEPTH     = 55,
  parameter int                 SHORT_LAG = 24,
  parameter logic [WORD_W-1:0]  AUTO_SEED = 32'hACE12468,
  parameter logic [WORD_W-1:0]  LFSR_TAPS = 32'h80200003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [WORD_W-1:0] seed_data,
  input  logic              auto_seed,
  input  logic              enable,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              seed_ready,
  output logic              seed_all_even
);
  import lfg_pkg::*;

  localparam int PTR_W   = $clog2(DEPTH);
  localparam int LAG_OFS = DEPTH - SHORT_LAG;

  lfg_state_e st_q;
  logic       odd_seen_q;

  // Named internal events (observed by the bound checker).
  logic              in_auto, auto_req, man_req, man_restart;
  logic              fill_write, fill_done, gen_step, ptr_step;
  logic [WORD_W-1:0] fill_data, wr_data, lfsr_q, old_word, lag_word, sum_word;
  logic [PTR_W-1:0]  wr_addr, lag_addr, wr_ptr;

  function automatic logic [WORD_W-1:0] lag_sum(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
    return a + b;  // wraps modulo 2^WORD_W
  endfunction

  assign in_auto     = (st_q == ST_AUTO);
  assign auto_req    = auto_seed & ~in_auto;
  assign man_req     = seed_load & ~in_auto & ~auto_seed;
  assign man_restart = man_req & (st_q != ST_MANUAL);
  assign gen_step    = (st_q == ST_RUN) & enable & ~seed_load & ~auto_seed;
  assign fill_write  = man_req | in_auto;
  assign fill_data   = in_auto ? lfsr_q : seed_data;
  assign fill_done   = fill_write & (wr_addr == PTR_W'(DEPTH - 1));
  assign ptr_step    = fill_write | gen_step;
  assign sum_word    = lag_sum(lag_word, old_word);
  assign wr_data     = gen_step ? sum_word : fill_data;

  lfg_ptr #(.DEPTH(DEPTH), .OFS(LAG_OFS), .PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (auto_req),
    .step     (ptr_step),
    .restart  (man_restart),
    .wr_addr  (wr_addr),
    .lag_addr (lag_addr),
    .cur_ptr  (wr_ptr)
  );

  lfg_hist #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ptr_step),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_a_addr (wr_addr),
    .rd_b_addr (lag_addr),
    .rd_a_data (old_word),
    .rd_b_data (lag_word)
  );

  lfg_lfsr #(.W(WORD_W), .TAPS(LFSR_TAPS), .SEED(AUTO_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (auto_req),
    .step  (in_auto),
    .state (lfsr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_EMPTY;
      odd_seen_q <= 1'b0;
    end else begin
      if (auto_req)         st_q <= ST_AUTO;
      else if (fill_done)   st_q <= ST_RUN;
      else if (man_restart) st_q <= ST_MANUAL;

      if (auto_req)         odd_seen_q <= 1'b0;
      else if (man_restart) odd_seen_q <= seed_data[0];
      else if (fill_write)  odd_seen_q <= odd_seen_q | fill_data[0];
    end
  end

  assign word_valid    = gen_step;
  assign word_out      = gen_step ? sum_word : '0;
  assign seed_ready    = (st_q == ST_RUN);
  assign seed_all_even = (st_q == ST_RUN) & ~odd_seen_q;
endmodule

// File: rtl/lfg_gen_chk.sv
module lfg_gen_chk #(
  parameter int DEPTH = 55,
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seed_load,
  input logic             auto_seed,
  input logic             enable,
  input logic [31:0]      word_out,
  input logic             word_valid,
  input logic             seed_ready,
  input logic             seed_all_even,
  input logic             in_auto,
  input logic             gen_step,
  input logic             fill_done,
  input logic [PTR_W-1:0] wr_ptr
);
  a_r4_valid_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (seed_ready && enable && !seed_load && !auto_seed));

  a_r4_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> (word_out == '0));

  a_r8_auto_silent: assert property (@(posedge clk) disable iff (!rst_n)
    in_auto |-> (!word_valid && !seed_ready));

  a_r2_ready_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> seed_ready);

  a_r9_reload_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_ready && seed_load && !auto_seed) |=> !seed_ready);

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_ready && !enable && !seed_load && !auto_seed) |=> ($stable(wr_ptr) && seed_ready));

  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, wr_ptr} < (PTR_W+1)'(DEPTH)));

  a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_step && wr_ptr == PTR_W'(DEPTH - 1)) |=> (wr_ptr == '0));

  a_r7_auto_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_seed && !in_auto) |=> (in_auto && !seed_ready));

  a_r6_even_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    seed_all_even |-> seed_ready);
endmodule

bind lfg_gen lfg_gen_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .seed_load     (seed_load),
  .auto_seed     (auto_seed),
  .enable        (enable),
  .word_out      (word_out),
  .word_valid    (word_valid),
  .seed_ready    (seed_ready),
  .seed_all_even (seed_all_even),
  .in_auto       (in_auto),
  .gen_step      (gen_step),
  .fill_done     (fill_done),
  .wr_ptr        (wr_ptr)
);

// File: tb/lfg_gen_bench.sv
module lfg_gen_bench;
  localparam logic [31:0] ASEED = 32'hACE12468;
  localparam logic [31:0] TAPS  = 32'h80200003;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        seed_load = 1'b0, auto_seed = 1'b0, enable = 1'b0;
  logic [31:0] seed_data = '0;
  logic [31:0] word_out;
  logic        word_valid, seed_ready, seed_all_even;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] model[$];   // oldest first: element k is x(n-55+k)
  logic [31:0] expq[$];

  lfg_gen u_lfg_gen (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_data(seed_data),
    .auto_seed(auto_seed), .enable(enable), .word_out(word_out),
    .word_valid(word_valid), .seed_ready(seed_ready), .seed_all_even(seed_all_even)
  );

  always #2 clk = ~clk;  // 250 MHz

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic model_step(output logic [31:0] v);
    v = model[31] + model[0];   // short lag 24, long lag 55
    void'(model.pop_front());
    model.push_back(v);
  endtask

  // Monitor: pops the scoreboard whenever the design presents a word.
  always @(negedge clk) begin : mon
    logic [31:0] e;
    if (rst_n && word_valid) begin
      if (expq.size() == 0) check(1'b0, "R4", "word without request", word_out, 32'h0);
      else begin
        e = expq.pop_front();
        check(word_out == e, "R3", "generated word", word_out, e);
      end
    end
  end

  function automatic logic [31:0] seed_word(input int kind, input int i);
    logic [31:0] v;
    case (kind)
      0: v = 32'(i) * 32'h9E3779B9 + 32'h01234567;
      1: v = (32'(i) + 32'd7) * 32'h85EBCA6B ^ 32'h5A5A5A5A;
      2: v = (32'(i) * 32'h01000193) << 1;
      default: v = ((32'(i) * 32'h01000193) << 1) | ((i == 40) ? 32'h1 : 32'h0);
    endcase
    return v;
  endfunction

  // Manual seeding with enable held high as noise (R10).
  task automatic manual_seed(input int kind);
    logic [31:0] w;
    model = {};
    for (int i = 0; i < 55; i++) begin
      cyc();
      w = seed_word(kind, i);
      seed_load = 1'b1; seed_data = w; enable = 1'b1;
      @(negedge clk);
      check(!word_valid, "R10", "seed_load over enable", {31'b0, word_valid}, 32'h0);
      if (i >= 1) check(!seed_ready, "R9", "ready during fill", {31'b0, seed_ready}, 32'h0);
      model.push_back(w);
    end
    cyc();
    seed_load = 1'b0; enable = 1'b0;
    @(negedge clk);
    check(seed_ready, "R2", "ready after 55 loads", {31'b0, seed_ready}, 32'h1);
  endtask

  task automatic run_words(input int n, input int gap);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      cyc();
      enable = ((i % gap) != (gap / 2));
      if (enable) begin
        model_step(v);
        expq.push_back(v);
      end
      @(negedge clk);
      if (!enable) begin
        check(!word_valid, "R5", "idle cycle valid", {31'b0, word_valid}, 32'h0);
        check(word_out == '0, "R4", "idle word zero", word_out, 32'h0);
      end
    end
    cyc();
    enable = 1'b0;
    @(negedge clk);
    check(expq.size() == 0, "R4", "words missing", 32'(expq.size()), 32'h0);
  endtask

  task automatic auto_fill();
    logic [31:0] s;
    cyc();
    auto_seed = 1'b1; seed_load = 1'b1; seed_data = 32'hFFFF_FFFF; enable = 1'b1;
    @(negedge clk);
    check(!word_valid, "R10", "auto_seed over enable", {31'b0, word_valid}, 32'h0);
    for (int i = 1; i <= 55; i++) begin
      cyc();
      auto_seed = (i % 3 == 0); seed_load = (i % 2 == 0); enable = 1'b1;
      @(negedge clk);
      check(!word_valid, "R8", "word during auto fill", {31'b0, word_valid}, 32'h0);
      check(!seed_ready, "R7", "ready during auto fill", {31'b0, seed_ready}, 32'h0);
    end
    cyc();
    auto_seed = 1'b0; seed_load = 1'b0; enable = 1'b0;
    @(negedge clk);
    check(seed_ready, "R7", "ready after auto fill", {31'b0, seed_ready}, 32'h1);
    model = {};
    s = ASEED;
    for (int i = 0; i < 55; i++) begin
      model.push_back(s);
      s = {1'b0, s[31:1]} ^ (s[0] ? TAPS : 32'h0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung actual=%h expected=%h", 32'h0, 32'h1);
    summary();
  end

  initial begin : stim
    enable = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(!word_valid && !seed_ready && !seed_all_even && word_out == '0, "R1",
            "outputs in reset", {28'b0, word_valid, seed_ready, seed_all_even, |word_out}, 32'h0);
    end
    cyc();
    rst_n = 1'b1;
    @(negedge clk);
    check(!word_valid && !seed_ready && !seed_all_even, "R1", "outputs after reset",
          {29'b0, word_valid, seed_ready, seed_all_even}, 32'h0);
    check(word_out == '0, "R4", "no word while empty", word_out, 32'h0);

    manual_seed(0);
    check(!seed_all_even, "R6", "flag with odd seed", {31'b0, seed_all_even}, 32'h0);
    run_words(3000, 7);

    manual_seed(1);   // restart while running (R9)
    run_words(400, 4);

    manual_seed(2);
    check(seed_all_even, "R6", "flag with all-even seed", {31'b0, seed_all_even}, 32'h1);
    run_words(100, 9);

    manual_seed(3);
    check(!seed_all_even, "R6", "flag with one odd word", {31'b0, seed_all_even}, 32'h0);
    run_words(100, 9);

    auto_fill();
    check(!seed_all_even, "R6", "flag after auto fill", {31'b0, seed_all_even}, 32'h0);
    run_words(2000, 5);

    summary();
  end
endmodule